// File: doc/BRIEF.md
# Packed SIMD Lane Arithmetic Unit

This block performs integer arithmetic on packed vectors. Each operand is a vector of 64 or 128 bits, and a run-time element-size field splits it into independent lanes of 8, 16, 32 or 64 bits. All lanes are computed in the same cycle, and no carry, borrow or clamp crosses a lane boundary. The unit offers wrapping add and subtract, saturating add and subtract in signed or unsigned form, and a widening multiply. The widening multiply takes the low 64 bits of each source and writes double-width products across the whole 128-bit result.

Each operation is presented with a single-cycle valid strobe, and its registered result appears exactly one clock later. A sticky flag records that at least one active lane was clamped, and it stays set until software-visible logic pulses a clear input. A request that the unit cannot perform (a widening multiply of 64-bit lanes, or an unused opcode) gives a zero result and raises an error output alongside the output strobe.

Top module: `simd_lane_alu`

## Requirements
- R1: With opcode 0 (add) or 1 (subtract), each lane holds the low bits of the lane sum or difference, wrapped modulo 2^W. Lane width W is 8, 16, 32 or 64 for esize codes 0, 1, 2 or 3. Lane i occupies result bits [i*W +: W].
- R2: When full_width is 1, opcodes 0 to 3 process all 128 bits. When it is 0, only the low 64 bits are processed, result bits [127:64] are zero, and the upper lanes cannot saturate.
- R3: With opcode 2 (saturating add) or 3 (saturating subtract) and is_signed = 1, a lane whose exact result falls outside [-2^(W-1), 2^(W-1)-1] is replaced by the nearest bound.
- R4: With opcode 2 or 3 and is_signed = 0, a lane whose exact result exceeds 2^W-1 becomes all ones, and a lane whose result falls below zero becomes zero.
- R5: sat_flag is set one cycle after an accepted saturating operation clamps at least one active lane. It stays set until sat_clear is sampled high, which clears it on the next edge. Clear wins over a clamp in the same cycle. Wrapping operations never set it.
- R6: With opcode 4 (widening multiply), lane i of width W (esize 0 to 2) is taken from bits [i*W +: W] of the low 64 bits of each source. Its 2W-bit product, signed or unsigned according to is_signed, is written to result bits [i*2W +: 2W]. The setting of full_width has no effect on this opcode.
- R7: Opcode 4 with esize 3, or any opcode from 5 to 7, gives an all-zero result and size_err = 1 together with out_valid. Such a request never sets sat_flag.
- R8: out_valid equals in_valid delayed by one clock. result holds its value in cycles without in_valid, and size_err is 0 when out_valid is 0.
- R9: While rst is high, out_valid, result, sat_flag and size_err are all zero after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request strobe |
| op_a | input | 128 | First source vector |
| op_b | input | 128 | Second source vector |
| opcode | input | 3 | 0 add, 1 sub, 2 sat add, 3 sat sub, 4 widening multiply |
| esize | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | Signed interpretation of lanes |
| full_width | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 128 | Registered result vector |
| sat_flag | output | 1 | Sticky saturation indicator |
| size_err | output | 1 | Unsupported request indicator |

## Verification
The sweep replicates lane-boundary values (zero, one, the signed extremes and all ones) into every lane, then adds random vectors, for every opcode, lane size, signedness and vector width. If a carry leaked between lanes, a value such as all ones plus one would corrupt the next lane up. If the overflow test were wrong, a signed clamp would saturate to the wrong bound or an unsigned subtract would wrap instead of clamping to zero. If the multiply did not extend its operands by sign, signed products of the minimum value would be wrong. Periodic clear pulses that coincide with clamps, and idle cycles carrying changed operands, would expose a flag that ignores clear priority or a result register that loads without a strobe.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'd0,
    OPC_SUB  = 3'd1,
    OPC_QADD = 3'd2,
    OPC_QSUB = 3'd3,
    OPC_WMUL = 3'd4
  } simd_opc_e;

  localparam int unsigned SIZE_CODES = 4;
  localparam int unsigned BASE_LANE  = 8;

  function automatic logic opc_is_sat(input logic [2:0] opc);
    return (opc == OPC_QADD) || (opc == OPC_QSUB);
  endfunction

  function automatic logic opc_is_sub(input logic [2:0] opc);
    return (opc == OPC_SUB) || (opc == OPC_QSUB);
  endfunction

endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat_en,
  input  logic         is_signed,
  output logic [W-1:0] y,
  output logic         sat
);
  logic [W:0]   ax, bx, s;
  logic         ovf;
  logic [W-1:0] bound;

  always_comb begin
    ax = {is_signed & a[W-1], a};
    bx = {is_signed & b[W-1], b};
    s  = sub ? (ax - bx) : (ax + bx);
    if (is_signed) begin
      ovf   = s[W] ^ s[W-1];
      bound = s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      ovf   = s[W];
      bound = sub ? '0 : '1;
    end
    sat = sat_en & ovf;
    y   = sat ? bound : s[W-1:0];
  end
endmodule

// File: rtl/simd_lane_wmul.sv
module simd_lane_wmul #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           is_signed,
  output logic [2*W-1:0] p
);
  logic [2*W-1:0] ax, bx;

  always_comb begin
    ax = {{W{is_signed & a[W-1]}}, a};
    bx = {{W{is_signed & b[W-1]}}, b};
    p  = ax * bx;
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic [2:0]       opcode,
  input  logic [1:0]       esize,
  input  logic             is_signed,
  input  logic             full_width,
  input  logic             sat_clear,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag,
  output logic             size_err
);
  localparam int unsigned HALF_W = VEC_W / 2;
  localparam int unsigned NSZ    = SIZE_CODES;
  localparam int unsigned NMUL   = NSZ - 1;

  logic             sub_sel, sat_sel;
  logic             bad_req;
  logic [VEC_W-1:0] as_res  [NSZ];
  logic             as_sat  [NSZ];
  logic [VEC_W-1:0] mul_res [NMUL];
  logic [VEC_W-1:0] half_mask;
  logic [VEC_W-1:0] next_res;
  logic             next_sat;

  assign sub_sel   = opc_is_sub(opcode);
  assign sat_sel   = opc_is_sat(opcode);
  assign bad_req   = (opcode > OPC_WMUL) ||
                     ((opcode == OPC_WMUL) && (esize == 2'(NSZ - 1)));
  assign half_mask = full_width ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  // Add / subtract lanes, one bank per element size.
  for (genvar s = 0; s < NSZ; s++) begin : g_as
    localparam int unsigned LW = BASE_LANE << s;
    localparam int unsigned NL = VEC_W / LW;
    logic [VEC_W-1:0] y;
    logic [NL-1:0]    lane_sat;
    logic [NL-1:0]    lane_act;

    for (genvar i = 0; i < NL; i++) begin : g_ln
      simd_lane_addsub #(.W(LW)) u_lane (
        .a         (op_a[i*LW +: LW]),
        .b         (op_b[i*LW +: LW]),
        .sub       (sub_sel),
        .sat_en    (sat_sel),
        .is_signed (is_signed),
        .y         (y[i*LW +: LW]),
        .sat       (lane_sat[i])
      );
      assign lane_act[i] = full_width | (i < NL / 2);
    end

    assign as_res[s] = y;
    assign as_sat[s] = |(lane_sat & lane_act);
  end

  // Widening multiply lanes on the low half of each source.
  for (genvar s = 0; s < NMUL; s++) begin : g_mul
    localparam int unsigned LW = BASE_LANE << s;
    localparam int unsigned NL = HALF_W / LW;
    logic [VEC_W-1:0] y;

    for (genvar i = 0; i < NL; i++) begin : g_ln
      simd_lane_wmul #(.W(LW)) u_mul (
        .a         (op_a[i*LW +: LW]),
        .b         (op_b[i*LW +: LW]),
        .is_signed (is_signed),
        .p         (y[i*2*LW +: 2*LW])
      );
    end

    assign mul_res[s] = y;
  end

  always_comb begin
    next_res = '0;
    next_sat = 1'b0;
    if (!bad_req) begin
      if (opcode == OPC_WMUL) begin
        for (int s = 0; s < NMUL; s++)
          if (esize == 2'(s)) next_res = mul_res[s];
      end else begin
        for (int s = 0; s < NSZ; s++)
          if (esize == 2'(s)) begin
            next_res = as_res[s] & half_mask;
            next_sat = as_sat[s];
          end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      size_err  <= in_valid & bad_req;
      if (in_valid) result <= next_res;
      if (sat_clear)     sat_flag <= 1'b0;
      else if (in_valid) sat_flag <= sat_flag | next_sat;
    end
  end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       opcode,
  input logic [1:0]       esize,
  input logic             full_width,
  input logic             sat_clear,
  input logic             out_valid,
  input logic [VEC_W-1:0] result,
  input logic             sat_flag,
  input logic             size_err
);
  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R8
  err_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    size_err |-> out_valid);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sat_clear |=> !sat_flag);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clear) |=> sat_flag);
  // R5
  wrap_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode < 3'd2 && !sat_flag) |=> !sat_flag);
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    size_err |-> (result == '0));
  // R7
  wide_mul_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd4 && esize == 2'd3) |=> size_err);
  // R2
  half_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !full_width && opcode < 3'd4) |=> (result[VEC_W-1:VEC_W/2] == '0));
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/simd_lane_alu_test.sv
`timescale 1ns/1ps
module simd_lane_alu_test;
  localparam time TCK = 8ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [2:0]   opcode = '0;
  logic [1:0]   esize = '0;
  logic         is_signed = 1'b0, full_width = 1'b1, sat_clear = 1'b0;
  logic         out_valid, sat_flag, size_err;
  logic [127:0] result;

  int n_chk = 0, n_fail = 0;
  bit exp_flag = 0;
  logic [127:0] last_res = '0;
  int op_count = 0;

  always #(TCK/2) clk = ~clk;

  simd_lane_alu uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .esize(esize), .is_signed(is_signed),
    .full_width(full_width), .sat_clear(sat_clear), .out_valid(out_valid),
    .result(result), .sat_flag(sat_flag), .size_err(size_err)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (op=%0d es=%0d sg=%0d fw=%0d)",
               tag, act, exp, opcode, esize, is_signed, full_width);
    end
  endtask

  function automatic logic signed [67:0] lane_val(input logic [127:0] v, input int i, input int w, input bit sg);
    logic [127:0] m, r;
    logic signed [67:0] x;
    m = (128'(1) << w) - 1;
    r = (v >> (i*w)) & m;
    x = $signed({4'b0, r[63:0]});
    if (sg && r[w-1]) x = x - (68'sd1 <<< w);
    return x;
  endfunction

  task automatic model(input logic [127:0] a, input logic [127:0] b, input int op, input int es,
                       input bit sg, input bit fw, output logic [127:0] r, output bit sat, output bit err);
    int w;
    logic [127:0] m1, m2;
    logic signed [67:0] x, y, z, hi, lo;
    logic signed [135:0] p;
    w = 8 << es;
    m1 = (128'(1) << w) - 1;
    r = '0; sat = 0;
    err = (op > 4) || (op == 4 && es == 3);
    if (err) return;
    if (op < 4) begin
      for (int i = 0; i < (fw ? 128 : 64) / w; i++) begin
        x = lane_val(a, i, w, sg);
        y = lane_val(b, i, w, sg);
        z = (op == 1 || op == 3) ? x - y : x + y;
        hi = sg ? (68'sd1 <<< (w-1)) - 1 : (68'sd1 <<< w) - 1;
        lo = sg ? -(68'sd1 <<< (w-1)) : 68'sd0;
        if (op >= 2) begin
          if (z > hi) begin z = hi; sat = 1; end
          else if (z < lo) begin z = lo; sat = 1; end
        end
        r = r | ((128'(z[63:0]) & m1) << (i*w));
      end
    end else begin
      m2 = (128'(1) << (2*w)) - 1;
      for (int i = 0; i < 64 / w; i++) begin
        x = lane_val(a, i, w, sg);
        y = lane_val(b, i, w, sg);
        p = x * y;
        r = r | ((p[127:0] & m2) << (i*2*w));
      end
    end
  endtask

  function automatic string tag_of(input int op, input bit sg, input bit fw);
    if (op >= 4) return "R6";
    if (op >= 2) return sg ? "R3" : "R4";
    return fw ? "R1" : "R2";
  endfunction

  function automatic logic [127:0] rep(input logic [63:0] v, input int es);
    logic [127:0] r;
    int w;
    w = 8 << es;
    r = '0;
    for (int i = 0; i < 128 / w; i++)
      r = r | ((128'(v) & ((128'(1) << w) - 1)) << (i*w));
    return r;
  endfunction

  // Drive at a falling edge, check at the next falling edge.
  task automatic do_op(input logic [127:0] a, input logic [127:0] b, input int op, input int es,
                       input bit sg, input bit fw);
    logic [127:0] er;
    bit es_sat, ee, clr;
    op_count++;
    clr = (op_count % 7 == 0);
    model(a, b, op, es, sg, fw, er, es_sat, ee);
    op_a = a; op_b = b; opcode = 3'(op); esize = 2'(es);
    is_signed = sg; full_width = fw; in_valid = 1'b1; sat_clear = clr;
    exp_flag = clr ? 1'b0 : (exp_flag | (es_sat & ~ee));
    @(negedge clk);
    in_valid = 1'b0; sat_clear = 1'b0;
    check(result == er, ee ? "R7" : tag_of(op, sg, fw), result, er);
    check(size_err == ee, "R7", 128'(size_err), 128'(ee));
    check(out_valid == 1'b1, "R8", 128'(out_valid), 128'(1));
    check(sat_flag == exp_flag, "R5", 128'(sat_flag), 128'(exp_flag));
    last_res = er;
    if (op_count % 5 == 0) begin
      op_a = ~a; op_b = b ^ 128'h5a5a;
      @(negedge clk);
      check(out_valid == 1'b0, "R8", 128'(out_valid), 128'(0));
      check(result == last_res, "R8", result, last_res);
      check(size_err == 1'b0, "R8", 128'(size_err), 128'(0));
      check(sat_flag == exp_flag, "R5", 128'(sat_flag), 128'(exp_flag));
    end
  endtask

  initial begin
    #(TCK * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] cv [5];
    logic [127:0] ra, rb;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", 128'(out_valid), 128'(0));
    check(result == '0, "R9", result, '0);
    check(sat_flag == 1'b0, "R9", 128'(sat_flag), 128'(0));
    check(size_err == 1'b0, "R9", 128'(size_err), 128'(0));
    rst = 1'b0;
    @(negedge clk);

    for (int es = 0; es < 4; es++) begin
      cv[0] = 64'd0;
      cv[1] = 64'd1;
      cv[2] = (64'd1 << ((8 << es) - 1)) - 64'd1;
      cv[3] = 64'd1 << ((8 << es) - 1);
      cv[4] = '1;
      for (int op = 0; op < 5; op++)
        for (int fw = 0; fw < 2; fw++)
          for (int sg = 0; sg < 2; sg++) begin
            for (int i = 0; i < 5; i++)
              for (int j = 0; j < 5; j++)
                do_op(rep(cv[i], es), rep(cv[j], es), op, es, sg[0], fw[0]);
            for (int k = 0; k < 12; k++) begin
              ra = {$urandom, $urandom, $urandom, $urandom};
              rb = {$urandom, $urandom, $urandom, $urandom};
              do_op(ra, rb, op, es, sg[0], fw[0]);
            end
          end
    end
    // R7 unused opcodes
    for (int op = 5; op < 8; op++)
      for (int es = 0; es < 4; es++)
        do_op(rep(64'h7f, 0), rep(64'h7f, 0), op, es, 1'b1, 1'b1);
    // R5 clamp followed by wrap keeps flag, explicit clear drops it
    do_op(rep(64'hff, 0), rep(64'h01, 0), 2, 0, 1'b0, 1'b1);
    do_op(rep(64'hff, 0), rep(64'h01, 0), 0, 0, 1'b0, 1'b1);
    sat_clear = 1'b1;
    @(negedge clk);
    sat_clear = 1'b0;
    exp_flag = 1'b0;
    check(sat_flag == 1'b0, "R5", 128'(sat_flag), 128'(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule